// File: doc/BRIEF.md
# Circular Sampling Window Controller

This block is the digital sequencer for one channel of a 64-cell circular sampling memory. While the channel is armed, a write pointer moves forward by one cell on every sampling step. After cell 63 it returns to cell 0, so the memory always holds the most recent 64 samples and each new sample overwrites the oldest. When a trigger arrives, the block copies the shared Gray-coded coarse counter into a timestamp register. It then lets sampling run for a selectable post-trigger delay and stops the pointer. The stopped pointer is the medium-precision time tag. It also marks the oldest cell in the window.

After the freeze, the block emits a stream of cell addresses for the readout logic, one address per clock. It can send the whole window, starting at the oldest cell. It can also send a region of interest: a run of consecutive cells that starts at a chosen offset from the cell written at the trigger, with a length that may change from one event to the next. When the readout is done the channel stays frozen until a rearm pulse arrives. Writing then resumes from the frozen cell.

The control is a five-state machine:
- SAMPLE: armed, writing.
- DELAY: post-trigger wait, still writing.
- TAG: one cycle, frozen and tagged.
- READ: address stream.
- HOLD: frozen, waiting for rearm.

Its transitions are:
- SAMPLE to TAG on a trigger when the delay setting is 0.
- SAMPLE to DELAY on a trigger when the setting is nonzero.
- DELAY to TAG on the last delay step.
- TAG to READ always.
- READ to HOLD on the last address.
- HOLD to SAMPLE on rearm.

Top module: `sample_window_ctrl`

## Requirements
- R1: During reset and right after it, `sampling_o` is 1, `wr_ptr_o` is 0, and `tag_valid_o` and `rd_valid_o` are 0.
- R2: While sampling, `wr_ptr_o` rises by one on each clock that has `step_i` high and wraps from 63 to 0. It does not move on a clock with `step_i` low.
- R3: With `dly_sel_i` = 0, a trigger seen at a clock edge stops sampling at that edge. The pointer does not advance on the trigger clock. In the next cycle `tag_valid_o` is 1 for exactly one cycle and `wr_ptr_o` equals the pointer value at the trigger.
- R4: With `dly_sel_i` = k > 0, sampling goes on for 8·k more steps after the trigger clock. The tag cycle then shows `wr_ptr_o` = (trigger pointer + 8·k) mod 64.
- R5: `tag_coarse_o` holds the value of `coarse_gray_i` sampled at the trigger edge. Later changes on `coarse_gray_i` do not affect it until the next accepted trigger.
- R6: With `roi_en_i` = 0, the cycle after the tag cycle starts a run of 64 consecutive cycles with `rd_valid_o` = 1. The addresses start at the frozen pointer and rise by one mod 64. `rd_last_o` is 1 only with the 64th address.
- R7: With `roi_en_i` = 1, sampled in the tag cycle, the stream holds `roi_len_i`+1 addresses. They start at (trigger pointer + `roi_ofs_i`) mod 64. Offset and length are taken per event.
- R8: A region of interest that passes cell 63 continues at cell 0.
- R9: A trigger is ignored in every state other than SAMPLE. It produces no tag, it does not restart the delay, and the frozen pointer does not move.
- R10: A rearm is ignored until the last address has been sent. In HOLD, a rearm sets `sampling_o` back to 1 in the next cycle with `wr_ptr_o` still at the frozen cell. Advancing then resumes from that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sampling-step decision per edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Sampling step strobe; advances the write pointer while writing |
| trig_i | input | 1 | Trigger request, acted on only in SAMPLE |
| coarse_gray_i | input | 16 | Shared free-running Gray-coded coarse counter |
| dly_sel_i | input | 3 | Post-trigger delay setting k, in eighths of the window |
| roi_en_i | input | 1 | 1 selects region-of-interest readout, 0 the full window |
| roi_ofs_i | input | 6 | ROI start offset from the trigger cell |
| roi_len_i | input | 6 | ROI length minus one |
| rearm_i | input | 1 | Restart writing after readout |
| sampling_o | output | 1 | Memory is being written (SAMPLE or DELAY) |
| wr_ptr_o | output | 6 | Write pointer; fine time tag once frozen |
| tag_valid_o | output | 1 | One-cycle pulse: pointer frozen and tag valid |
| tag_coarse_o | output | 16 | Coarse timestamp captured at the trigger |
| rd_valid_o | output | 1 | Read address valid |
| rd_addr_o | output | 6 | Cell address to read |
| rd_last_o | output | 1 | Marks the final address of the event |

## Verification
A trigger seen at an edge produces the tag one cycle later when k = 0, or 8·k+1 cycles later otherwise. The first read address follows one cycle after the tag, and the stream runs for exactly the expected length. HOLD begins one cycle after the last address. A rearm restores writing one cycle after the edge that sees it. The bench drives every input just after a falling edge and samples outputs at falling edges, counting edges from the trigger to each of these due cycles. The driver pushes the expected address and last-flag pairs into a queue at the tag cycle. A monitor pops one pair on every cycle with a valid address, so an early, late, missing or extra address is reported on the cycle it occurs.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [2:0] {
        ST_SAMPLE = 3'd0,
        ST_DELAY  = 3'd1,
        ST_TAG    = 3'd2,
        ST_READ   = 3'd3,
        ST_HOLD   = 3'd4
    } swc_state_e;

endpackage

// File: rtl/swc_wptr.sv
module swc_wptr #(
    parameter int CELLS = 64,
    localparam int PTR_W = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [PTR_W-1:0] ptr_o
);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_inc;

    generate
        if ((1 << PTR_W) == CELLS) begin : g_pow2
            assign ptr_inc = ptr_q + PTR_W'(1);
        end else begin : g_cmp
            assign ptr_inc = (ptr_q == PTR_W'(CELLS - 1)) ? '0 : ptr_q + PTR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (adv_i)
            ptr_q <= ptr_inc;
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/swc_delay.sv
module swc_delay #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             final_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (dec_i && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign final_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/swc_rdgen.sv
module swc_rdgen #(
    parameter int CELLS = 64,
    localparam int PTR_W = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PTR_W-1:0] start_addr_i,
    input  logic [PTR_W-1:0] len_m1_i,
    output logic             valid_o,
    output logic [PTR_W-1:0] addr_o,
    output logic             last_o
);

    logic             busy_q;
    logic [PTR_W-1:0] addr_q;
    logic [PTR_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            addr_q <= start_addr_i;
            rem_q  <= len_m1_i;
        end else if (busy_q) begin
            if (rem_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                addr_q <= addr_q + PTR_W'(1);
                rem_q  <= rem_q - PTR_W'(1);
            end
        end
    end

    assign valid_o = busy_q;
    assign addr_o  = addr_q;
    assign last_o  = busy_q && (rem_q == '0);

endmodule

// File: rtl/sample_window_ctrl.sv
module sample_window_ctrl
    import swc_pkg::*;
#(
    parameter int CELLS  = 64,
    parameter int DLY_W  = 3,
    parameter int GRAY_W = 16,
    localparam int PTR_W = $clog2(CELLS),
    localparam int DLY_SH = PTR_W - DLY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              trig_i,
    input  logic [GRAY_W-1:0] coarse_gray_i,
    input  logic [DLY_W-1:0]  dly_sel_i,
    input  logic              roi_en_i,
    input  logic [PTR_W-1:0]  roi_ofs_i,
    input  logic [PTR_W-1:0]  roi_len_i,
    input  logic              rearm_i,
    output logic              sampling_o,
    output logic [PTR_W-1:0]  wr_ptr_o,
    output logic              tag_valid_o,
    output logic [GRAY_W-1:0] tag_coarse_o,
    output logic              rd_valid_o,
    output logic [PTR_W-1:0]  rd_addr_o,
    output logic              rd_last_o
);

    swc_state_e        state_q, state_d;
    logic [PTR_W-1:0]  ptr;
    logic [PTR_W-1:0]  trig_cell_q;
    logic [GRAY_W-1:0] coarse_q;
    logic              accept_trig;
    logic              ptr_adv;
    logic              dly_final;
    logic [PTR_W-1:0]  dly_load;
    logic              rd_valid, rd_last;
    logic [PTR_W-1:0]  rd_addr;
    logic [PTR_W-1:0]  rd_start;
    logic [PTR_W-1:0]  rd_len_m1;

    assign accept_trig = (state_q == ST_SAMPLE) && trig_i;
    assign dly_load    = {dly_sel_i, {DLY_SH{1'b0}}};
    assign ptr_adv     = ((state_q == ST_SAMPLE) && step_i && !trig_i) ||
                         ((state_q == ST_DELAY) && step_i);

    swc_wptr #(.CELLS(CELLS)) wptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (ptr_adv),
        .ptr_o (ptr)
    );

    swc_delay #(.CNT_W(PTR_W)) delay_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept_trig),
        .load_val_i (dly_load),
        .dec_i      ((state_q == ST_DELAY) && step_i),
        .final_o    (dly_final)
    );

    // Start cell and length of the address stream, taken in the tag cycle.
    always_comb begin
        if (roi_en_i) begin
            rd_start  = trig_cell_q + roi_ofs_i;
            rd_len_m1 = roi_len_i;
        end else begin
            rd_start  = ptr;
            rd_len_m1 = PTR_W'(CELLS - 1);
        end
    end

    swc_rdgen #(.CELLS(CELLS)) rdgen_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (state_q == ST_TAG),
        .start_addr_i (rd_start),
        .len_m1_i     (rd_len_m1),
        .valid_o      (rd_valid),
        .addr_o       (rd_addr),
        .last_o       (rd_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_cell_q <= '0;
            coarse_q    <= '0;
        end else if (accept_trig) begin
            trig_cell_q <= ptr;
            coarse_q    <= coarse_gray_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: if (trig_i)
                           state_d = (dly_sel_i == '0) ? ST_TAG : ST_DELAY;
            ST_DELAY:  if (step_i && dly_final)
                           state_d = ST_TAG;
            ST_TAG:    state_d = ST_READ;
            ST_READ:   if (rd_last)
                           state_d = ST_HOLD;
            ST_HOLD:   if (rearm_i)
                           state_d = ST_SAMPLE;
            default:   state_d = ST_SAMPLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SAMPLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        sampling_o   = (state_q == ST_SAMPLE) || (state_q == ST_DELAY);
        tag_valid_o  = (state_q == ST_TAG);
        wr_ptr_o     = ptr;
        tag_coarse_o = coarse_q;
        rd_valid_o   = rd_valid;
        rd_addr_o    = rd_addr;
        rd_last_o    = rd_last;
    end

endmodule

// File: rtl/swc_chk.sv
module swc_chk #(
    parameter int CELLS  = 64,
    parameter int GRAY_W = 16,
    localparam int PTR_W = $clog2(CELLS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sampling_o,
    input logic [PTR_W-1:0]  wr_ptr_o,
    input logic              tag_valid_o,
    input logic [GRAY_W-1:0] tag_coarse_o,
    input logic              rd_valid_o,
    input logic [PTR_W-1:0]  rd_addr_o,
    input logic              rd_last_o
);

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr_o != $past(wr_ptr_o)) |-> (wr_ptr_o == PTR_W'($past(wr_ptr_o) + 1'b1)));

    // R10
    ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sampling_o |=> $stable(wr_ptr_o));

    // R3
    tag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid_o |=> !tag_valid_o);

    // R6
    tag_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid_o |=> rd_valid_o);

    // R6
    rd_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_last_o) |=> (rd_valid_o && rd_addr_o == PTR_W'($past(rd_addr_o) + 1'b1)));

    // R5
    coarse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sampling_o |=> $stable(tag_coarse_o));

    // R9
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sampling_o, tag_valid_o, rd_valid_o}));

    // R6
    last_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last_o |-> rd_valid_o);

endmodule

bind sample_window_ctrl swc_chk #(.CELLS(CELLS), .GRAY_W(GRAY_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sampling_o   (sampling_o),
    .wr_ptr_o     (wr_ptr_o),
    .tag_valid_o  (tag_valid_o),
    .tag_coarse_o (tag_coarse_o),
    .rd_valid_o   (rd_valid_o),
    .rd_addr_o    (rd_addr_o),
    .rd_last_o    (rd_last_o)
);

// File: tb/sample_window_ctrl_tb_top.sv
module sample_window_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        trig_i = 1'b0;
    logic [15:0] coarse_gray_i = '0;
    logic [2:0]  dly_sel_i = '0;
    logic        roi_en_i = 1'b0;
    logic [5:0]  roi_ofs_i = '0;
    logic [5:0]  roi_len_i = '0;
    logic        rearm_i = 1'b0;
    logic        sampling_o;
    logic [5:0]  wr_ptr_o;
    logic        tag_valid_o;
    logic [15:0] tag_coarse_o;
    logic        rd_valid_o;
    logic [5:0]  rd_addr_o;
    logic        rd_last_o;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;
    logic [6:0] exp_q[$];

    always #2.5 clk = ~clk;

    sample_window_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .trig_i(trig_i),
        .coarse_gray_i(coarse_gray_i), .dly_sel_i(dly_sel_i),
        .roi_en_i(roi_en_i), .roi_ofs_i(roi_ofs_i), .roi_len_i(roi_len_i),
        .rearm_i(rearm_i), .sampling_o(sampling_o), .wr_ptr_o(wr_ptr_o),
        .tag_valid_o(tag_valid_o), .tag_coarse_o(tag_coarse_o),
        .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .rd_last_o(rd_last_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: each valid address must match the head of the scoreboard (R6, R7, R8).
    always @(negedge clk) begin
        if (rst_n && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected address", int'(rd_addr_o), -1);
            end else begin
                logic [6:0] e;
                e = exp_q.pop_front();
                chk({rd_last_o, rd_addr_o} == e, "R6/R7/R8 address+last",
                    int'({rd_last_o, rd_addr_o}), int'(e));
            end
        end
    end

    // One event: trigger, optional delay, tag, readout, hold, rearm.
    task automatic run_event(input int k, input bit roi, input int want_start,
                             input int len_m1, input logic [15:0] cval,
                             input bit trig_in_delay, input bit rearm_in_read);
        int p, tagp, start, n;
        @(negedge clk);
        p = int'(wr_ptr_o);
        dly_sel_i = 3'(k);
        roi_en_i = roi;
        roi_ofs_i = 6'((want_start - p) & 63);
        roi_len_i = 6'(len_m1);
        coarse_gray_i = cval;
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        coarse_gray_i = ~cval;
        for (int i = 0; i < 8 * k; i++) begin
            chk(sampling_o == 1'b1, "R4 sampling during delay", int'(sampling_o), 1);
            if (trig_in_delay && i == 2) trig_i = 1'b1;
            if (i == 3) trig_i = 1'b0;
            @(negedge clk);
        end
        trig_i = 1'b0;
        tagp = (p + 8 * k) & 63;
        chk(tag_valid_o == 1'b1, "R3/R4 tag cycle", int'(tag_valid_o), 1);
        chk(sampling_o == 1'b0, "R3 sampling stopped", int'(sampling_o), 0);
        chk(int'(wr_ptr_o) == tagp, "R3/R4 frozen pointer", int'(wr_ptr_o), tagp);
        chk(tag_coarse_o == cval, "R5 coarse timestamp", int'(tag_coarse_o), int'(cval));
        start = roi ? (want_start & 63) : tagp;
        n = roi ? len_m1 + 1 : 64;
        for (int i = 0; i < n; i++)
            exp_q.push_back({(i == n - 1), 6'((start + i) & 63)});
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rearm_i = (rearm_in_read && i == 0);
            if (trig_in_delay && i == 0) begin
                chk(tag_valid_o == 1'b0, "R9 no second tag", int'(tag_valid_o), 0);
            end
        end
        rearm_i = 1'b0;
        @(negedge clk);
        chk(exp_q.size() == 0, "R6 stream complete", exp_q.size(), 0);
        chk(rd_valid_o == 1'b0, "R6 stream ended", int'(rd_valid_o), 0);
        chk(sampling_o == 1'b0, "R10 still frozen after read", int'(sampling_o), 0);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        chk(tag_valid_o == 1'b0, "R9 trigger in hold ignored", int'(tag_valid_o), 0);
        chk(int'(wr_ptr_o) == tagp, "R9 pointer kept in hold", int'(wr_ptr_o), tagp);
        @(negedge clk);
        chk(rd_valid_o == 1'b0 && sampling_o == 1'b0, "R9 no restart", int'(rd_valid_o), 0);
        rearm_i = 1'b1;
        @(negedge clk);
        rearm_i = 1'b0;
        chk(sampling_o == 1'b1, "R10 rearmed", int'(sampling_o), 1);
        chk(int'(wr_ptr_o) == tagp, "R10 resume cell", int'(wr_ptr_o), tagp);
        @(negedge clk);
        chk(int'(wr_ptr_o) == ((tagp + 1) & 63), "R10 resume advance", int'(wr_ptr_o), (tagp + 1) & 63);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sampling_o == 1'b1, "R1 sampling", int'(sampling_o), 1);
        chk(wr_ptr_o == 6'd0, "R1 pointer", int'(wr_ptr_o), 0);
        chk(tag_valid_o == 1'b0 && rd_valid_o == 1'b0, "R1 idle outputs",
            int'({tag_valid_o, rd_valid_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_ptr_o == 6'd0, "R2 no step no move", int'(wr_ptr_o), 0);
        chk(sampling_o == 1'b1 && tag_valid_o == 1'b0, "R1 after release",
            int'({sampling_o, tag_valid_o}), 2);
        step_i = 1'b1;
        for (int i = 0; i < 70; i++) begin
            int prev;
            prev = int'(wr_ptr_o);
            @(negedge clk);
            chk(int'(wr_ptr_o) == ((prev + 1) & 63), "R2 advance/wrap", int'(wr_ptr_o), (prev + 1) & 63);
        end
        step_i = 1'b0;
        @(negedge clk);
        begin
            int hold;
            hold = int'(wr_ptr_o);
            @(negedge clk);
            chk(int'(wr_ptr_o) == hold, "R2 paused step", int'(wr_ptr_o), hold);
        end
        step_i = 1'b1;
        // R3, R6: immediate stop, full window
        run_event(0, 1'b0, 0, 0, 16'h1234, 1'b0, 1'b0);
        // R4, R9: delay of 3 eighths, trigger during delay ignored
        run_event(3, 1'b0, 0, 0, 16'hBEEF, 1'b1, 1'b0);
        // R7: ROI without wrap
        run_event(0, 1'b1, 10, 9, 16'h0F0F, 1'b0, 1'b0);
        // R8, R10: ROI crossing cell 63, longest delay, rearm during read ignored
        run_event(7, 1'b1, 58, 15, 16'h8001, 1'b0, 1'b1);
        // R7: single-cell ROI at cell 63
        run_event(1, 1'b1, 63, 0, 16'h5A5A, 1'b0, 1'b0);
        // R7, R8: full-length ROI
        run_event(2, 1'b1, 40, 63, 16'hC3C3, 1'b0, 1'b0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule